// File: doc/BRIEF.md
# System Exception Pending Controller

This block keeps the pending state of three system exceptions: the non-maskable exception (number 2), a software-raised deferred service exception (number 14) and the periodic tick exception (number 15). Software reaches it through a simple synchronous register port. Writes take effect on the clock edge, and reads are combinational from the address. Hardware raises pending state through a tick pulse and an NMI request. The exception-entry logic clears it through one acknowledge input per exception.

The block also stores a 4-bit priority value for each configurable handler. It compares the two configurable pending exceptions and reports the winning exception number. It also holds a key-protected application control register. That register stores the priority-grouping and endianness bits, raises a sticky system reset request, and emits a one-cycle "clear active state" pulse. The pulse is produced only while the core reports that it is halted.

Top module: `exc_pend_ctrl`

## Requirements
- R1: After reset, all three pending states are 0, the winning number is 0, `isr_pend`, `sys_reset_req` and `clr_active` are 0, and every priority, grouping and endianness field reads 0.
- R2: The tick exception becomes pending on a `tick_pulse` or on a write to 0xD04 with bit 26 set. It is cleared by `ack_tick`, or by a 0xD04 write with bit 26 = 0 and bit 25 = 1. A write with both bits set leaves it pending. Its state reads back on 0xD04 bit 26.
- R3: The software exception becomes pending only through a 0xD04 write with bit 28 set. It is cleared by `ack_sv`, or by a write with bit 28 = 0 and bit 27 = 1. Its state reads back on bit 28. Bits 27 and 25 always read 0.
- R4: NMI becomes pending on `nmi_req` or on a 0xD04 write with bit 31 set, and `ack_nmi` clears it. Its state reads back on bit 31.
- R5: `pend_num` and 0xD04 bits 17:12 give the number of the winning pending exception, with 0 meaning none. `isr_pend` and bit 22 are 1 exactly when the software or tick exception is pending; NMI does not count.
- R6: A pending NMI always wins. Between the software and tick exceptions, the lower priority value wins, and on equal values the software exception (14) wins.
- R7: The tick priority is held at 0xD20 bits 31:28, the software-exception priority at 0xD20 bits 23:20, and the SVCall priority at 0xD1C bits 31:28. All other bits of these registers read 0.
- R8: A write to 0xD0C is accepted only when bits 31:16 equal 0x05FA; any other key leaves every output and field unchanged. Reads of 0xD0C give the grouping value in bits 10:8 and endianness in bit 15, and 0 in all other bits.
- R9: An accepted 0xD0C write with bit 2 set raises `sys_reset_req` on the next edge, and it stays high until `rst_n` is asserted.
- R10: An accepted 0xD0C write with bit 1 set produces a one-cycle `clr_active` pulse on the next edge, but only if `halted` is high in the write cycle.
- R11: When a pend source (hardware input or set bit) and a clear (software clear or acknowledge) for the same exception fall in one cycle, the exception ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tick_pulse | input | 1 | Periodic tick event, pends exception 15 |
| nmi_req | input | 1 | NMI request |
| ack_nmi | input | 1 | NMI handler entry |
| ack_sv | input | 1 | Software exception handler entry |
| ack_tick | input | 1 | Tick handler entry |
| halted | input | 1 | Core halted, enables the active-state clear |
| pend_num | output | 6 | Winning pending exception number, 0 for none |
| isr_pend | output | 1 | Software or tick exception pending |
| sys_reset_req | output | 1 | Sticky system reset request |
| clr_active | output | 1 | One-cycle clear-active-state pulse |

## Verification
The bench attacks the paired-clear rule with writes that set the clear bit and the set bit together. A design that honoured the clear bit alone would drop the pending state there. It drives pend and clear into the same cycle, where a clear-wins design would lose the event. It also ties the two priorities, where a design that let the higher exception number win would report 15 instead of 14.

Control writes are sent with wrong keys and with `halted` low. A key-blind design would then raise reset or pulse `clr_active` without cause. Random traffic is compared cycle by cycle against a reference model.

// File: rtl/exc_pend_ctrl.sv
module exc_pend_ctrl #(
  parameter int          AW   = 12,
  parameter int          DW   = 32,
  parameter int          PW   = 4,
  parameter int          NW   = 6,
  parameter logic [15:0] KEY  = 16'h05FA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tick_pulse,
  input  logic          nmi_req,
  input  logic          ack_nmi,
  input  logic          ack_sv,
  input  logic          ack_tick,
  input  logic          halted,
  output logic [NW-1:0] pend_num,
  output logic          isr_pend,
  output logic          sys_reset_req,
  output logic          clr_active
);
  localparam logic [AW-1:0] A_ICS = AW'(12'hD04);
  localparam logic [AW-1:0] A_AIC = AW'(12'hD0C);
  localparam logic [AW-1:0] A_PR2 = AW'(12'hD1C);
  localparam logic [AW-1:0] A_PR3 = AW'(12'hD20);
  localparam logic [NW-1:0] N_NMI = NW'(2);
  localparam logic [NW-1:0] N_SV  = NW'(14);
  localparam logic [NW-1:0] N_TK  = NW'(15);

  logic          nmi_p, sv_p, tk_p;
  logic [PW-1:0] pri_svc, pri_sv, pri_tk;
  logic [2:0]    grp;
  logic          endian;

  wire wr_ics = bus_we && bus_addr == A_ICS;
  wire wr_aic = bus_we && bus_addr == A_AIC && bus_wdata[31:16] == KEY;

  wire tk_set = tick_pulse | (wr_ics & bus_wdata[26]);
  wire tk_clr = ack_tick   | (wr_ics & ~bus_wdata[26] & bus_wdata[25]);
  wire sv_set = wr_ics & bus_wdata[28];
  wire sv_clr = ack_sv     | (wr_ics & ~bus_wdata[28] & bus_wdata[27]);
  wire nm_set = nmi_req    | (wr_ics & bus_wdata[31]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_p <= 1'b0; sv_p <= 1'b0; tk_p <= 1'b0;
      pri_svc <= '0; pri_sv <= '0; pri_tk <= '0;
      grp <= '0; endian <= 1'b0;
      sys_reset_req <= 1'b0; clr_active <= 1'b0;
    end else begin
      tk_p  <= tk_set | (tk_p  & ~tk_clr);
      sv_p  <= sv_set | (sv_p  & ~sv_clr);
      nmi_p <= nm_set | (nmi_p & ~ack_nmi);
      if (bus_we && bus_addr == A_PR2) pri_svc <= bus_wdata[31 -: PW];
      if (bus_we && bus_addr == A_PR3) begin
        pri_tk <= bus_wdata[31 -: PW];
        pri_sv <= bus_wdata[23 -: PW];
      end
      if (wr_aic) begin
        grp    <= bus_wdata[10:8];
        endian <= bus_wdata[15];
      end
      sys_reset_req <= sys_reset_req | (wr_aic & bus_wdata[2]);
      clr_active    <= wr_aic & bus_wdata[1] & halted;
    end
  end

  wire tk_wins = tk_p & (~sv_p | (pri_tk < pri_sv));

  assign isr_pend = sv_p | tk_p;
  assign pend_num = nmi_p   ? N_NMI :
                    tk_wins ? N_TK  :
                    sv_p    ? N_SV  : '0;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_ICS: begin
        bus_rdata[31]    = nmi_p;
        bus_rdata[28]    = sv_p;
        bus_rdata[26]    = tk_p;
        bus_rdata[22]    = isr_pend;
        bus_rdata[17:12] = pend_num;
      end
      A_AIC: begin
        bus_rdata[15]   = endian;
        bus_rdata[10:8] = grp;
      end
      A_PR2: bus_rdata[31 -: PW] = pri_svc;
      A_PR3: begin
        bus_rdata[31 -: PW] = pri_tk;
        bus_rdata[23 -: PW] = pri_sv;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/exc_pend_ctrl_chk.sv
module exc_pend_ctrl_chk #(
  parameter int          AW  = 12,
  parameter int          DW  = 32,
  parameter int          NW  = 6,
  parameter logic [15:0] KEY = 16'h05FA
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          tick_pulse,
  input logic          nmi_req,
  input logic          ack_nmi,
  input logic          halted,
  input logic [NW-1:0] pend_num,
  input logic          isr_pend,
  input logic          sys_reset_req,
  input logic          clr_active
);
  wire aic_ok  = bus_we && bus_addr == AW'(12'hD0C) && bus_wdata[31:16] == KEY;
  wire ics_nmi = bus_we && bus_addr == AW'(12'hD04) && bus_wdata[31];

  p_tick_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_pulse |=> pend_num != '0);

  p_nmi_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_nmi && !nmi_req && !ics_nmi) |=> pend_num != NW'(2));

  p_isr_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !isr_pend |-> (pend_num == '0 || pend_num == NW'(2)));

  p_nmi_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> pend_num == NW'(2));

  p_key_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_reset_req) |-> $past(aic_ok && bus_wdata[2]));

  p_rst_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> sys_reset_req);

  p_clr_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_active |-> $past(aic_ok && bus_wdata[1] && halted));

  p_clr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_active && !(aic_ok && bus_wdata[1] && halted)) |=> !clr_active);
endmodule

bind exc_pend_ctrl exc_pend_ctrl_chk #(.AW(AW), .DW(DW), .NW(NW), .KEY(KEY)) u_chk (.*);

// File: tb/sim_exc_pend_ctrl.sv
`timescale 1ns/1ps
module sim_exc_pend_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        tick = 1'b0, nmi = 1'b0, anmi = 1'b0, asv = 1'b0, atk = 1'b0, hlt = 1'b0;
  logic [5:0]  num;
  logic        isr, srst, clra;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  logic       m_nmi, m_sv, m_tk, m_end, m_rst, m_clr;
  logic [3:0] m_psvc, m_psv, m_ptk;
  logic [2:0] m_grp;

  always #4 clk = ~clk;

  exc_pend_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .tick_pulse(tick), .nmi_req(nmi), .ack_nmi(anmi),
    .ack_sv(asv), .ack_tick(atk), .halted(hlt), .pend_num(num),
    .isr_pend(isr), .sys_reset_req(srst), .clr_active(clra));

  function automatic logic [5:0] exp_num();
    if (m_nmi) return 6'd2;
    if (m_tk && (!m_sv || m_ptk < m_psv)) return 6'd15;
    if (m_sv) return 6'd14;
    return 6'd0;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    logic [31:0] r = '0;
    case (a)
      12'hD04: begin
        r[31] = m_nmi; r[28] = m_sv; r[26] = m_tk;
        r[22] = m_sv | m_tk; r[17:12] = exp_num();
      end
      12'hD0C: begin r[15] = m_end; r[10:8] = m_grp; end
      12'hD1C: r[31:28] = m_psvc;
      12'hD20: begin r[31:28] = m_ptk; r[23:20] = m_psv; end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_nmi = 0; m_sv = 0; m_tk = 0; m_end = 0; m_rst = 0; m_clr = 0;
    m_psvc = 0; m_psv = 0; m_ptk = 0; m_grp = 0;
  endtask

  task automatic step(input logic w, input logic [11:0] a, input logic [31:0] d,
                      input logic tp, input logic nr, input logic an,
                      input logic as, input logic at, input logic h);
    logic ics, aic;
    @(negedge clk);
    we = w; addr = a; wdata = d; tick = tp; nmi = nr; anmi = an; asv = as; atk = at; hlt = h;
    @(posedge clk); #1;
    ics = w && a == 12'hD04;
    aic = w && a == 12'hD0C && d[31:16] == 16'h05FA;
    m_tk  = (tp | (ics & d[26])) | (m_tk & ~(at | (ics & ~d[26] & d[25])));
    m_sv  = (ics & d[28]) | (m_sv & ~(as | (ics & ~d[28] & d[27])));
    m_nmi = (nr | (ics & d[31])) | (m_nmi & ~an);
    if (w && a == 12'hD1C) m_psvc = d[31:28];
    if (w && a == 12'hD20) begin m_ptk = d[31:28]; m_psv = d[23:20]; end
    if (aic) begin m_grp = d[10:8]; m_end = d[15]; end
    m_rst = m_rst | (aic & d[2]);
    m_clr = aic & d[1] & h;
    we = 0; tick = 0; nmi = 0; anmi = 0; asv = 0; atk = 0;
    chk("R10 clr_active", 32'(clra), 32'(m_clr));
    chk("R9 sys_reset_req", 32'(srst), 32'(m_rst));
  endtask

  task automatic rd(input string tag, input logic [11:0] a);
    addr = a; #1;
    chk(tag, rdata, exp_rd(a));
  endtask

  task automatic check_all();
    chk("R5 pend_num", 32'(num), 32'(exp_num()));
    chk("R5 isr_pend", 32'(isr), 32'(m_sv | m_tk));
    rd("R2 R3 R4 ics readback", 12'hD04);
    rd("R7 pri3 readback", 12'hD20);
    rd("R7 pri2 readback", 12'hD1C);
    rd("R8 aic readback", 12'hD0C);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 pend_num", 32'(num), 0);
    chk("R1 flags", {29'd0, isr, srst, clra}, 0);
    check_all();

    // R6 tie: equal priorities, software exception wins
    step(1, 12'hD20, 32'h5050_0000, 0,0,0,0,0,0);
    step(1, 12'hD04, 32'h1400_0000, 0,0,0,0,0,0);
    chk("R6 tie pend_num", 32'(num), 14);
    step(1, 12'hD20, 32'h2050_0000, 0,0,0,0,0,0);
    chk("R6 lower value wins", 32'(num), 15);
    step(0, 12'h000, 0, 0,1,0,0,0,0);
    chk("R6 nmi over all", 32'(num), 2);
    // R2 set+clear bits both 1: stays pending; R11 pend vs clear
    step(1, 12'hD04, 32'h0600_0000, 0,0,0,0,0,0);
    rd("R2 both bits kept", 12'hD04);
    step(1, 12'hD04, 32'h0200_0000, 1,0,0,0,0,0);
    chk("R11 tick pend vs clear", 32'(rdata[26]), 1);
    step(0, 12'h000, 0, 0,1,1,0,0,0);
    chk("R11 nmi req vs ack", 32'(num), 2);
    step(0, 12'h000, 0, 0,0,1,0,0,0);
    chk("R4 nmi ack clears", 32'(num), 15);
    step(1, 12'hD04, 32'h1000_0000, 0,0,0,1,0,0);
    rd("R11 sv set vs ack", 12'hD04);
    step(1, 12'hD04, 32'h0A00_0000, 0,0,0,0,0,0);
    rd("R3 paired clear both", 12'hD04);
    chk("R3 none pending", 32'(num), 0);
    // R8 bad key ignored, R10 halted gate
    step(1, 12'hD0C, 32'h05FB_8706, 0,0,0,0,0,1);
    rd("R8 bad key ignored", 12'hD0C);
    step(1, 12'hD0C, 32'h05FA_8302, 0,0,0,0,0,0);
    rd("R8 good key stored", 12'hD0C);
    step(1, 12'hD0C, 32'h05FA_0002, 0,0,0,0,0,1);
    check_all();

    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      int sel = $urandom_range(0, 5);
      a = (sel == 0) ? 12'hD04 : (sel == 1) ? 12'hD0C : (sel == 2) ? 12'hD1C :
          (sel == 3) ? 12'hD20 : (sel == 4) ? 12'hD04 : 12'h010;
      d = $urandom();
      if (a == 12'hD0C) begin
        d[2] = 1'b0;
        if ($urandom_range(0, 1) == 1) d[31:16] = 16'h05FA;
      end
      step($urandom_range(0, 2) != 0, a, d,
           $urandom_range(0, 5) == 0, $urandom_range(0, 9) == 0,
           $urandom_range(0, 4) == 0, $urandom_range(0, 4) == 0,
           $urandom_range(0, 4) == 0, $urandom_range(0, 1) == 1);
      check_all();
    end

    // R9 reset request: bad key then good key, sticky until reset
    step(1, 12'hD0C, 32'h1234_0004, 0,0,0,0,0,0);
    step(1, 12'hD0C, 32'h05FA_0004, 0,0,0,0,0,0);
    chk("R9 raised", 32'(srst), 1);
    step(0, 12'h000, 0, 0,0,0,0,0,0);
    chk("R9 held", 32'(srst), 1);
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1; rst_n = 1; model_reset();
    chk("R1 R9 cleared by reset", 32'(srst), 0);
    check_all();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule